// File: doc/BRIEF.md
# Coarse/Fine Acquisition Loop Filter

This block is the digital loop filter of a fractional-N digital PLL, together with the sequencer that runs frequency acquisition. On every reference cycle it takes a signed phase error. It scales the error by a programmable open-loop gain and smooths it with a first-order IIR lowpass. It then steers the filtered value into one of two tuning paths, depending on the acquisition phase.

After reset the sequencer sits in a clear phase for a programmable number of cycles. It then spends a programmable number of cycles in coarse tuning, and then stays in fine tuning. In coarse tuning an integrator alone moves the 10-bit coarse DAC code. The proportional term goes out to be added to the divider's modulator input, and the fine code rests at mid-scale. In fine tuning the coarse code is frozen and a proportional-plus-integral path, kept with four fractional bits, moves the fine code through a first-order sigma-delta requantizer. Entering fine tuning also raises the enable for quantization-noise cancellation.

Top module: `acq_loop_filter`

## Requirements
- R1: While rst_ni is low, and throughout the clear phase, phase_o is 0, both codes are 512, div_mod_o is 0 and qnc_en_o is 0, whatever phase_err_i is.
- R2: The phase code on phase_o is 0 for clear, 1 for coarse and 2 for fine. Clear lasts clr_len_i reference cycles and coarse lasts coarse_len_i cycles, with a length of 0 acting as 1. Fine is never left except through reset.
- R3: The scaled error is phase_err_i * gain_i / 256, using an arithmetic shift right by 8.
- R4: The filtered error y advances once per cycle by (scaled - y) >>> iir_shift_i. It is cleared during the clear phase.
- R5: In coarse, the coarse code grows by y >>> ki_shift_i per cycle, one cycle after y, and saturates at 0 and 1023.
- R6: div_mod_o equals y >>> kp_shift_i during coarse and is 0 in every other phase.
- R7: The fine code stays at 512 until the first cycle in the fine phase.
- R8: In fine, the coarse code holds its last value and qnc_en_o is 1. qnc_en_o is 0 in every other phase.
- R9: In fine, an integrator in 1/16-code units grows by y >>> ki_shift_i per cycle. The sum of the integrator and y >>> kp_shift_i is requantized by a first-order sigma-delta, so the fine code averages that sum divided by 16. With a steady input of 8200/16, sixteen consecutive codes are each 512 or 513 and add up to 8200.
- R10: In fine, the integrator and the sum both saturate, so the fine code stays within 0 to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, one update per edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_err_i | input | 12 | Signed phase error |
| gain_i | input | 12 | Unsigned open-loop gain, 256 = unity |
| iir_shift_i | input | 4 | IIR pole shift |
| kp_shift_i | input | 4 | Proportional shift |
| ki_shift_i | input | 4 | Integral shift |
| clr_len_i | input | 16 | Cycles in the clear phase |
| coarse_len_i | input | 16 | Cycles in the coarse phase |
| phase_o | output | 2 | Acquisition phase: 0 clear, 1 coarse, 2 fine |
| coarse_code_o | output | 10 | Coarse DAC code |
| fine_code_o | output | 10 | Fine DAC code |
| div_mod_o | output | 25 | Signed proportional term for the divider modulator |
| qnc_en_o | output | 1 | Quantization-noise cancellation enable |

## Verification
The filtered error y is registered, so div_mod_o follows the phase error after one edge. The coarse integrator and the fine sigma-delta register each add a second edge, and a new phase appears on phase_o at the edge that ends the previous phase's count. Each bench task releases reset on a falling edge and then counts falling edges. For coarse edge k, the coarse code is expected to be 512 plus (k-1) increments; for fine edge j, the ramp code is expected to be 511 + j. Every sample is taken on a falling edge, half a period clear of the update.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    PH_CLR    = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } acq_phase_e;
endpackage

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] clr_len_i,
  input  logic [CNT_W-1:0] coarse_len_i,
  output acq_phase_e       phase_o
);
  acq_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   len, cnt_nx;
  logic             last;

  assign len    = {1'b0, (phase_q == PH_CLR) ? clr_len_i : coarse_len_i};
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign last   = cnt_nx >= len; // zero length behaves as one

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CLR;
      cnt_q   <= '0;
    end else if (phase_q != PH_FINE) begin
      if (last) begin
        phase_q <= (phase_q == PH_CLR) ? PH_COARSE : PH_FINE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_nx[CNT_W-1:0];
      end
    end
  end

  assign phase_o = phase_q;

  // R2
  phase_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3);
  // R2
  fine_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FINE |=> phase_q == PH_FINE);
  // R2
  no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_CLR |=> phase_q != PH_FINE);
endmodule

// File: rtl/acq_pre_filt.sv
module acq_pre_filt #(
  parameter int PE_W      = 12,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 8,
  parameter int SH_W      = 4,
  localparam int YW       = PE_W + GAIN_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic signed [PE_W-1:0] err_i,
  input  logic [GAIN_W-1:0]      gain_i,
  input  logic [SH_W-1:0]        shift_i,
  output logic signed [YW-1:0]   y_o
);
  logic signed [YW-1:0] prod, scaled, y_q;
  logic signed [YW:0]   diff;

  assign prod   = YW'(err_i) * $signed({1'b0, gain_i});
  assign scaled = prod >>> GAIN_FRAC;
  assign diff   = {scaled[YW-1], scaled} - {y_q[YW-1], y_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    y_q <= '0;
    else if (clr_i) y_q <= '0;
    else            y_q <= y_q + YW'(diff >>> shift_i);
  end

  assign y_o = y_q;

  // R4
  iir_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> y_q == '0);
endmodule

// File: rtl/acq_sd1.sv
module acq_sd1 #(
  parameter int CODE_W = 10,
  parameter int FRAC   = 4,
  localparam int FW    = CODE_W + FRAC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [FW-1:0]     val_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  logic [FRAC-1:0]   err_q;
  logic [CODE_W-1:0] code_q;
  logic [FW:0]       t_sum;

  assign t_sum = {1'b0, val_i} + {{(FW + 1 - FRAC){1'b0}}, err_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      code_q <= MID;
    end else if (clr_i) begin
      err_q  <= '0;
      code_q <= MID;
    end else begin
      err_q  <= t_sum[FRAC-1:0];
      code_q <= t_sum[FW-1:FRAC];
    end
  end

  assign code_o = code_q;

  // R10
  sd_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> !t_sum[FW]);
endmodule

// File: rtl/acq_loop_filter.sv
module acq_loop_filter
  import acq_pkg::*;
#(
  parameter int PE_W      = 12,
  parameter int GAIN_W    = 12,
  parameter int GAIN_FRAC = 8,
  parameter int SH_W      = 4,
  parameter int CODE_W    = 10,
  parameter int SD_FRAC   = 4,
  parameter int CNT_W     = 16,
  localparam int YW       = PE_W + GAIN_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [PE_W-1:0] phase_err_i,
  input  logic [GAIN_W-1:0]      gain_i,
  input  logic [SH_W-1:0]        iir_shift_i,
  input  logic [SH_W-1:0]        kp_shift_i,
  input  logic [SH_W-1:0]        ki_shift_i,
  input  logic [CNT_W-1:0]       clr_len_i,
  input  logic [CNT_W-1:0]       coarse_len_i,
  output logic [1:0]             phase_o,
  output logic [CODE_W-1:0]      coarse_code_o,
  output logic [CODE_W-1:0]      fine_code_o,
  output logic signed [YW-1:0]   div_mod_o,
  output logic                   qnc_en_o
);
  localparam int FW = CODE_W + SD_FRAC;
  localparam int SW = YW + 2;
  localparam logic [CODE_W-1:0] MID     = CODE_W'(1 << (CODE_W - 1));
  localparam logic [FW-1:0]     F_MID   = {MID, {SD_FRAC{1'b0}}};
  localparam logic [FW-1:0]     F_MAX   = {{CODE_W{1'b1}}, {SD_FRAC{1'b0}}};
  localparam logic signed [SW-1:0] C_MAX_S = SW'((1 << CODE_W) - 1);
  localparam logic signed [SW-1:0] F_MAX_S = SW'({1'b0, F_MAX});

  acq_phase_e           phase;
  logic                 in_clr, in_coarse, in_fine;
  logic signed [YW-1:0] y, prop, inc;
  logic signed [SW-1:0] inc_x, prop_x, c_sum, f_sum, pi_sum;
  logic [CODE_W-1:0]    cacc_q, cacc_d;
  logic [FW-1:0]        facc_q, facc_d, pi_sat;

  acq_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_len_i   (clr_len_i),
    .coarse_len_i(coarse_len_i),
    .phase_o     (phase)
  );

  assign in_clr    = phase == PH_CLR;
  assign in_coarse = phase == PH_COARSE;
  assign in_fine   = phase == PH_FINE;

  acq_pre_filt #(
    .PE_W(PE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .SH_W(SH_W)
  ) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (in_clr),
    .err_i  (phase_err_i),
    .gain_i (gain_i),
    .shift_i(iir_shift_i),
    .y_o    (y)
  );

  assign prop   = y >>> kp_shift_i;
  assign inc    = y >>> ki_shift_i;
  assign inc_x  = SW'(inc);
  assign prop_x = SW'(prop);

  // coarse integrator: code units, no requantizer
  assign c_sum = $signed({{(SW - CODE_W){1'b0}}, cacc_q}) + inc_x;
  always_comb begin
    if (c_sum < 0)             cacc_d = '0;
    else if (c_sum > C_MAX_S)  cacc_d = '1;
    else                       cacc_d = c_sum[CODE_W-1:0];
  end

  // fine integrator and PI sum: 1/2^SD_FRAC code units
  assign f_sum  = $signed({{(SW - FW){1'b0}}, facc_q}) + inc_x;
  assign pi_sum = $signed({{(SW - FW){1'b0}}, facc_q}) + prop_x;
  always_comb begin
    if (f_sum < 0)             facc_d = '0;
    else if (f_sum > F_MAX_S)  facc_d = F_MAX;
    else                       facc_d = f_sum[FW-1:0];
    if (pi_sum < 0)            pi_sat = '0;
    else if (pi_sum > F_MAX_S) pi_sat = F_MAX;
    else                       pi_sat = pi_sum[FW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cacc_q <= MID;
      facc_q <= F_MID;
    end else begin
      if (in_clr)         cacc_q <= MID;
      else if (in_coarse) cacc_q <= cacc_d;
      if (in_fine)        facc_q <= facc_d;
      else                facc_q <= F_MID;
    end
  end

  acq_sd1 #(.CODE_W(CODE_W), .FRAC(SD_FRAC)) u_sd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!in_fine),
    .val_i (pi_sat),
    .code_o(fine_code_o)
  );

  assign phase_o       = phase;
  assign coarse_code_o = cacc_q;
  assign div_mod_o     = in_coarse ? prop : '0;
  assign qnc_en_o      = in_fine;

  // R1
  clr_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_CLR |-> coarse_code_o == MID && fine_code_o == MID);
  // R7
  fine_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != PH_FINE |-> fine_code_o == MID);
  // R8
  coarse_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_FINE |=> $stable(coarse_code_o));
  // R6
  div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != PH_COARSE |-> div_mod_o == '0);
endmodule

// File: tb/acq_loop_filter_tb.sv
module acq_loop_filter_tb;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [11:0] err = '0;
  logic [11:0]        gain = 12'd256;
  logic [3:0]         iir_sh = '0, kp_sh = '0, ki_sh = '0;
  logic [15:0]        clr_len = 16'd4, coarse_len = 16'd20;
  logic [1:0]         phase;
  logic [9:0]         ccode, fcode;
  logic signed [24:0] div_mod;
  logic               qnc_en;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  acq_loop_filter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_err_i(err), .gain_i(gain),
    .iir_shift_i(iir_sh), .kp_shift_i(kp_sh), .ki_shift_i(ki_sh),
    .clr_len_i(clr_len), .coarse_len_i(coarse_len), .phase_o(phase),
    .coarse_code_o(ccode), .fine_code_o(fcode), .div_mod_o(div_mod),
    .qnc_en_o(qnc_en)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int cl, input int co, input int ish, input int kp,
                         input int ki, input int g, input int e);
    @(negedge clk);
    rst_ni = 1'b0;
    clr_len = 16'(cl); coarse_len = 16'(co);
    iir_sh = 4'(ish); kp_sh = 4'(kp); ki_sh = 4'(ki);
    gain = 12'(g); err = 12'(e);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset;
    restart(4, 20, 0, 0, 0, 256, 2000);
    chk("R1 phase", phase, 0);
    chk("R1 coarse", ccode, 512);
    chk("R1 fine", fcode, 512);
    chk("R1 div", div_mod, 0);
    chk("R1 qnc", qnc_en, 0);
    step(3);
    chk("R1 coarse in clear", ccode, 512);
    chk("R1 div in clear", div_mod, 0);
    chk("R2 still clear", phase, 0);
    step(1);
    chk("R2 coarse entered", phase, 1);
  endtask

  task automatic t_coarse_int;
    restart(4, 40, 0, 0, 1, 256, 8);
    step(4 + 10);
    chk("R5 coarse ramp", ccode, 548);
    chk("R6 div in coarse", div_mod, 8);
    chk("R7 fine rests", fcode, 512);
    chk("R8 qnc off", qnc_en, 0);
    err = -12'sd8;
    step(6);
    chk("R5 coarse down", ccode, 532);
    chk("R6 div negative", div_mod, -8);
  endtask

  task automatic t_gain;
    restart(2, 40, 0, 0, 0, 128, 8);
    step(2 + 6);
    chk("R3 half gain ramp", ccode, 532);
    chk("R3 half gain div", div_mod, 4);
  endtask

  task automatic t_iir;
    restart(2, 40, 1, 0, 15, 256, 64);
    step(3);
    chk("R4 iir step1", div_mod, 32);
    step(1);
    chk("R4 iir step2", div_mod, 48);
    step(1);
    chk("R4 iir step3", div_mod, 56);
    chk("R5 zero increment", ccode, 512);
  endtask

  task automatic t_coarse_sat;
    restart(2, 40, 0, 0, 0, 256, 2000);
    step(2 + 5);
    chk("R5 sat high", ccode, 1023);
    err = -12'sd2000;
    step(3);
    chk("R5 sat low", ccode, 0);
  endtask

  task automatic t_lengths;
    restart(1, 3, 0, 0, 0, 256, 0);
    step(1);
    chk("R2 clear len 1", phase, 1);
    step(2);
    chk("R2 coarse len 3 mid", phase, 1);
    step(1);
    chk("R2 fine entered", phase, 2);
    chk("R8 qnc on", qnc_en, 1);
    step(5);
    chk("R2 fine sticky", phase, 2);
    restart(0, 0, 0, 0, 0, 256, 0);
    step(1);
    chk("R2 zero clear len", phase, 1);
    step(1);
    chk("R2 zero coarse len", phase, 2);
  endtask

  task automatic t_fine_ramp;
    restart(2, 20, 0, 15, 0, 256, 16);
    step(2 + 20);
    chk("R2 fine reached", phase, 2);
    chk("R5 coarse final", ccode, 816);
    chk("R7 fine before update", fcode, 512);
    step(1);
    chk("R9 fine edge1", fcode, 512);
    step(10);
    chk("R9 fine ramp", fcode, 522);
    chk("R8 coarse frozen", ccode, 816);
    chk("R6 div zero in fine", div_mod, 0);
  endtask

  task automatic t_sd;
    int sum = 0, bad = 0;
    restart(2, 4, 0, 0, 15, 256, 8);
    step(2 + 2);
    chk("R6 div coarse", div_mod, 8);
    step(2);
    chk("R7 fine at entry", fcode, 512);
    for (int i = 0; i < 16; i++) begin
      step(1);
      sum += int'(fcode);
      if (fcode != 10'd512 && fcode != 10'd513) bad++;
    end
    chk("R9 sd code range", bad, 0);
    chk("R9 sd sum", sum, 8200);
    chk("R6 div fine", div_mod, 0);
  endtask

  task automatic t_fine_sat;
    restart(2, 3, 0, 0, 0, 256, 2047);
    step(2 + 3 + 12);
    chk("R10 fine sat high", fcode, 1023);
    err = -12'sd2047;
    step(12);
    chk("R10 fine sat low", fcode, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_coarse_int();
    t_gain();
    t_iir();
    t_coarse_sat();
    t_lengths();
    t_fine_ramp();
    t_sd();
    t_fine_sat();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule